// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block recovers asynchronous serial characters from a single receive line. The line is first passed through a two-flop synchronizer. It is then sampled only on cycles where an external sample-rate tick is high. Each bit period spans 16 samples in normal mode and 8 in double-speed mode. Every bit, including the start and stop bits, is decided by a majority of three samples taken around the middle of the bit.

A character consists of a start bit, 5 to 9 data bits sent least-significant first, an optional parity bit and one stop bit. After the stop bit is voted, the block emits a one-cycle strobe together with the character and two error flags. The receiver does not wait out the tail of the stop bit. A falling edge seen on the very next sample after the stop-bit vote opens a new character. A start bit whose mid-bit vote reads high is dropped as noise.

Baud-rate generation belongs to the surrounding logic. The host drives `tick_i` at 16 times the bit rate in normal mode, or 8 times the bit rate in double-speed mode.

Top module: `uart_rx_sampler`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `frame_err_o`, `parity_err_o` and `data_o` are all 0.
- R2: With `dbl_i`=0, a bit lasts 16 ticks. Counting from 1 at the first low sample of the start bit, the bit value is voted from samples 8, 9 and 10 of each bit. Data arrives LSB first and is right-aligned in `data_o`, with unused upper bits 0. `valid_o` rises only in the cycle after a tick.
- R3: With `dbl_i`=1, a bit lasts 8 ticks, and samples 4, 5 and 6 of each bit are voted.
- R4: A single voting sample that disagrees with the other two does not change the decided bit.
- R5: `data_bits_i` selects the number of data bits, 5 to 9. A value below 5 acts as 5, and a value above 9 acts as 9.
- R6: `par_en_i`=1 inserts a parity bit after the data bits. `par_odd_i`=0 selects even parity and 1 selects odd parity. `parity_err_o` is 1 when the voted parity bit mismatches the parity of the voted data bits. With `par_en_i`=0, `parity_err_o` is 0.
- R7: A stop bit that votes 0 sets `frame_err_o` for that character. The data is still delivered.
- R8: `valid_o` is a one-cycle pulse, issued once per character. `data_o` and both flags change only together with that pulse and hold their values in between.
- R9: A low level whose start-bit vote reads 1 is discarded without any `valid_o`. The next proper character is then received normally.
- R10: A start bit whose first low sample falls on the sample right after the last stop-bit voting sample is accepted. Both characters are then received intact, in both speed modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Sample-rate enable, one cycle per sample |
| dbl_i | input | 1 | 1 selects 8 samples per bit, 0 selects 16 |
| data_bits_i | input | 4 | Number of data bits (5..9, clamped) |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 odd parity, 0 even parity |
| rxd_i | input | 1 | Asynchronous serial receive line |
| data_o | output | 9 | Received character, right-aligned |
| valid_o | output | 1 | One-cycle character strobe |
| frame_err_o | output | 1 | Stop bit voted 0 |
| parity_err_o | output | 1 | Parity mismatch |

## Verification
Two functions can meet in adjacent decisions. The first is the stop-bit vote that closes one character and raises the strobe. The second is the start detection of the next character on the following tick. The bench provokes this by ending the stop bit right after its last voting sample and starting the next start bit at once, in both speed modes. It then judges that both characters arrive with their own data and no frame error. A second overlap is checked as well: a character carrying both a low stop bit and a wrong parity bit must raise both flags on the same strobe.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];

endmodule

// File: rtl/uart_rx_bitclk.sv
// Sample counter and three-sample vote around the bit middle.
module uart_rx_bitclk #(
  parameter int OSR_NORM = 16,
  parameter int OSR_DBL  = 8,
  parameter int CW       = $clog2(OSR_NORM + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          dbl_i,
  input  logic          rx_i,
  input  logic          start_i,
  input  logic          run_i,
  output logic [CW-1:0] cnt_o,
  output logic          bit_done_o,
  output logic          bit_val_o
);

  localparam int NMid = OSR_NORM / 2 + 1;
  localparam int DMid = OSR_DBL / 2 + 1;

  logic [CW-1:0] cnt_q, osr, mid, idx;
  logic          v0_q, v1_q;

  always_comb begin
    osr = dbl_i ? CW'(OSR_DBL) : CW'(OSR_NORM);
    mid = dbl_i ? CW'(DMid) : CW'(NMid);
    idx = (cnt_q >= osr) ? CW'(1) : cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      v0_q  <= 1'b1;
      v1_q  <= 1'b1;
    end else if (start_i) begin
      cnt_q <= CW'(1);
    end else if (run_i && tick_i) begin
      cnt_q <= idx;
      if (idx == mid - CW'(1)) v0_q <= rx_i;
      if (idx == mid)          v1_q <= rx_i;
    end
  end

  assign cnt_o      = cnt_q;
  assign bit_done_o = run_i && tick_i && (idx == mid + CW'(1));
  assign bit_val_o  = uart_rx_pkg::maj3(v0_q, v1_q, rx_i);

endmodule

// File: rtl/uart_rx_frame.sv
// Character framing: start check, data shift, parity, stop and strobe.
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_MIN = 5,
  parameter int DATA_MAX = 9,
  parameter int BW       = $clog2(DATA_MAX + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                rx_i,
  input  logic                bit_done_i,
  input  logic                bit_val_i,
  input  logic [BW-1:0]       data_bits_i,
  input  logic                par_en_i,
  input  logic                par_odd_i,
  output logic                start_o,
  output logic                run_o,
  output logic [DATA_MAX-1:0] data_o,
  output logic                valid_o,
  output logic                frame_err_o,
  output logic                parity_err_o
);

  rx_state_e           st_q;
  logic [BW-1:0]       nb, bit_idx_q;
  logic [DATA_MAX-1:0] shreg_q, data_q;
  logic                xor_q, perr_q, valid_q, fe_q, pe_q;

  always_comb begin
    if (data_bits_i < BW'(DATA_MIN))      nb = BW'(DATA_MIN);
    else if (data_bits_i > BW'(DATA_MAX)) nb = BW'(DATA_MAX);
    else                                  nb = data_bits_i;
  end

  assign start_o = (st_q == RX_IDLE) && tick_i && !rx_i;
  assign run_o   = (st_q != RX_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= RX_IDLE;
      bit_idx_q <= '0;
      shreg_q   <= '0;
      xor_q     <= 1'b0;
      perr_q    <= 1'b0;
      valid_q   <= 1'b0;
      data_q    <= '0;
      fe_q      <= 1'b0;
      pe_q      <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (st_q)
        RX_IDLE: if (start_o) begin
          st_q      <= RX_START;
          bit_idx_q <= '0;
          shreg_q   <= '0;
          xor_q     <= 1'b0;
          perr_q    <= 1'b0;
        end
        RX_START: if (bit_done_i) st_q <= bit_val_i ? RX_IDLE : RX_DATA;
        RX_DATA: if (bit_done_i) begin
          shreg_q[bit_idx_q] <= bit_val_i;
          xor_q              <= xor_q ^ bit_val_i;
          if (bit_idx_q == nb - BW'(1)) st_q <= par_en_i ? RX_PAR : RX_STOP;
          else                          bit_idx_q <= bit_idx_q + BW'(1);
        end
        RX_PAR: if (bit_done_i) begin
          perr_q <= bit_val_i ^ xor_q ^ par_odd_i;
          st_q   <= RX_STOP;
        end
        RX_STOP: if (bit_done_i) begin
          valid_q <= 1'b1;
          data_q  <= shreg_q;
          fe_q    <= !bit_val_i;
          pe_q    <= perr_q;
          st_q    <= RX_IDLE;  // next start may follow on the very next tick
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign data_o       = data_q;
  assign valid_o      = valid_q;
  assign frame_err_o  = fe_q;
  assign parity_err_o = pe_q;

endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler #(
  parameter int DATA_MIN = 5,
  parameter int DATA_MAX = 9,
  parameter int OSR_NORM = 16,
  parameter int OSR_DBL  = 8,
  parameter int SYNC_STG = 2,
  parameter int BW       = $clog2(DATA_MAX + 1),
  parameter int CW       = $clog2(OSR_NORM + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                dbl_i,
  input  logic [BW-1:0]       data_bits_i,
  input  logic                par_en_i,
  input  logic                par_odd_i,
  input  logic                rxd_i,
  output logic [DATA_MAX-1:0] data_o,
  output logic                valid_o,
  output logic                frame_err_o,
  output logic                parity_err_o
);

  logic          rx_s, start, run, bit_done, bit_val;
  logic [CW-1:0] smp_cnt;

  uart_rx_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rx_s)
  );

  uart_rx_bitclk #(.OSR_NORM(OSR_NORM), .OSR_DBL(OSR_DBL), .CW(CW)) u_bitclk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .dbl_i     (dbl_i),
    .rx_i      (rx_s),
    .start_i   (start),
    .run_i     (run),
    .cnt_o     (smp_cnt),
    .bit_done_o(bit_done),
    .bit_val_o (bit_val)
  );

  uart_rx_frame #(.DATA_MIN(DATA_MIN), .DATA_MAX(DATA_MAX), .BW(BW)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .rx_i        (rx_s),
    .bit_done_i  (bit_done),
    .bit_val_i   (bit_val),
    .data_bits_i (data_bits_i),
    .par_en_i    (par_en_i),
    .par_odd_i   (par_odd_i),
    .start_o     (start),
    .run_o       (run),
    .data_o      (data_o),
    .valid_o     (valid_o),
    .frame_err_o (frame_err_o),
    .parity_err_o(parity_err_o)
  );

endmodule

// File: rtl/uart_rx_sampler_chk.sv
module uart_rx_sampler_chk #(
  parameter int DATA_MAX = 9,
  parameter int OSR_NORM = 16,
  parameter int CW       = $clog2(OSR_NORM + 1)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                tick_i,
  input logic                par_en_i,
  input logic [DATA_MAX-1:0] data_o,
  input logic                valid_o,
  input logic                frame_err_o,
  input logic                parity_err_o,
  input logic                run_i,
  input logic [CW-1:0]       cnt_i
);

  p_valid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_out_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(data_o) && $stable(frame_err_o) && $stable(parity_err_o)));

  p_valid_after_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(tick_i));

  p_no_perr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !par_en_i) |-> !parity_err_o);

  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_i >= CW'(1) && cnt_i <= CW'(OSR_NORM)));

  p_start_on_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> $past(tick_i));

endmodule

bind uart_rx_sampler uart_rx_sampler_chk #(
  .DATA_MAX(DATA_MAX),
  .OSR_NORM(OSR_NORM),
  .CW      (CW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .par_en_i    (par_en_i),
  .data_o      (data_o),
  .valid_o     (valid_o),
  .frame_err_o (frame_err_o),
  .parity_err_o(parity_err_o),
  .run_i       (run),
  .cnt_i       (smp_cnt)
);

// File: tb/uart_rx_sampler_bench.sv
`timescale 1ns/1ps
module uart_rx_sampler_bench;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0;
  logic       dbl = 1'b0;
  logic [3:0] nbits_cfg = 4'd8;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       rxd = 1'b1;
  logic [8:0] data_o;
  logic       valid_o, frame_err_o, parity_err_o;

  int checks = 0;
  int errors = 0;
  int got_n = 0;
  int pulse_bad = 0;
  logic [8:0] got_data = '0, got_prev = '0;
  logic       got_fe = 1'b0, got_pe = 1'b0, valid_d = 1'b0;

  always #4 clk = ~clk;

  uart_rx_sampler u_uart_rx_sampler (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .dbl_i       (dbl),
    .data_bits_i (nbits_cfg),
    .par_en_i    (par_en),
    .par_odd_i   (par_odd),
    .rxd_i       (rxd),
    .data_o      (data_o),
    .valid_o     (valid_o),
    .frame_err_o (frame_err_o),
    .parity_err_o(parity_err_o)
  );

  always @(negedge clk) begin
    if (valid_o) begin
      got_n++;
      got_prev = got_data;
      got_data = data_o;
      got_fe   = frame_err_o;
      got_pe   = parity_err_o;
      if (valid_d) pulse_bad++;
    end
    valid_d = valid_o;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic smp(input logic v);
    @(negedge clk) rxd = v;
    repeat (2) @(negedge clk);
    tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic send_run(input logic v, input int n);
    for (int i = 0; i < n; i++) smp(v);
  endtask

  task automatic send_bit(input logic v, input int flip);
    int s = dbl ? 8 : 16;
    for (int i = 1; i <= s; i++) smp((i == flip) ? ~v : v);
  endtask

  function automatic int eff_bits();
    if (nbits_cfg < 5) return 5;
    if (nbits_cfg > 9) return 9;
    return int'(nbits_cfg);
  endfunction

  task automatic send_frame(input logic [8:0] val, input logic bad_par, input logic stop_v,
                            input int flip_bit, input int flip_smp, input bit short_stop);
    int nb = eff_bits();
    int s = dbl ? 8 : 16;
    int lastv = dbl ? 6 : 10;
    logic px = 1'b0;
    send_bit(1'b0, 0);
    for (int i = 0; i < nb; i++) begin
      send_bit(val[i], (i == flip_bit) ? flip_smp : 0);
      px ^= val[i];
    end
    if (par_en) send_bit(px ^ par_odd ^ bad_par, 0);
    send_run(stop_v, lastv);
    if (!short_stop) send_run(1'b1, s - lastv);
  endtask

  task automatic run_frame(input logic [8:0] val, input logic bad_par, input logic stop_v,
                           input int flip_bit, input int flip_smp, input string tag);
    int n0 = got_n;
    logic [8:0] exp = val & 9'((1 << eff_bits()) - 1);
    send_frame(val, bad_par, stop_v, flip_bit, flip_smp, 1'b0);
    send_run(1'b1, 4);
    check(got_n == n0 + 1, {tag, " count"}, got_n - n0, 1);
    check(got_data == exp, {tag, " data"}, got_data, exp);
    check(got_fe == !stop_v, {tag, " frame_err"}, got_fe, !stop_v);
    check(got_pe == (par_en & bad_par), {tag, " parity_err"}, got_pe, par_en & bad_par);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(valid_o == 0 && frame_err_o == 0 && parity_err_o == 0 && data_o == 0,
          "R1 reset outputs", {valid_o, frame_err_o, parity_err_o, data_o}, 0);
    rst_ni = 1'b1;
    send_run(1'b1, 4);
  endtask

  task automatic t_normal();
    dbl = 0; nbits_cfg = 8; par_en = 0;
    run_frame(9'h0A5, 0, 1, -1, 0, "R2 normal A5");
    run_frame(9'h03C, 0, 1, -1, 0, "R2 normal 3C");
    check(pulse_bad == 0, "R8 single-cycle strobe", pulse_bad, 0);
  endtask

  task automatic t_double();
    dbl = 1; nbits_cfg = 8; par_en = 0;
    run_frame(9'h05A, 0, 1, -1, 0, "R3 double 5A");
    run_frame(9'h0C3, 0, 1, -1, 0, "R3 double C3");
    dbl = 0;
  endtask

  task automatic t_majority();
    dbl = 0; nbits_cfg = 8;
    run_frame(9'h0F0, 0, 1, 2, 9, "R4 flip mid normal");
    run_frame(9'h00F, 0, 1, 5, 8, "R4 flip first normal");
    dbl = 1;
    run_frame(9'h066, 0, 1, 1, 6, "R4 flip last double");
    dbl = 0;
  endtask

  task automatic t_sizes();
    nbits_cfg = 5;  run_frame(9'h1FF, 0, 1, -1, 0, "R5 five bits");
    nbits_cfg = 9;  run_frame(9'h155, 0, 1, -1, 0, "R5 nine bits");
    nbits_cfg = 12; run_frame(9'h1A3, 0, 1, -1, 0, "R5 clamp high");
    nbits_cfg = 2;  run_frame(9'h1B6, 0, 1, -1, 0, "R5 clamp low");
    nbits_cfg = 8;
  endtask

  task automatic t_parity();
    par_en = 1; par_odd = 0;
    run_frame(9'h0B1, 0, 1, -1, 0, "R6 even good");
    run_frame(9'h0B1, 1, 1, -1, 0, "R6 even bad");
    par_odd = 1;
    run_frame(9'h072, 0, 1, -1, 0, "R6 odd good");
    run_frame(9'h072, 1, 1, -1, 0, "R6 odd bad");
    par_odd = 0;
  endtask

  task automatic t_frame_err();
    run_frame(9'h09C, 1, 0, -1, 0, "R7 stop low with bad parity");
    par_en = 0;
    run_frame(9'h011, 0, 0, -1, 0, "R7 stop low");
    run_frame(9'h022, 0, 1, -1, 0, "R7 recovery");
  endtask

  task automatic t_glitch();
    int n0 = got_n;
    send_run(1'b0, 4);
    send_run(1'b1, 40);
    check(got_n == n0, "R9 glitch dropped", got_n - n0, 0);
    run_frame(9'h0E7, 0, 1, -1, 0, "R9 after glitch");
  endtask

  task automatic t_back_to_back(input logic d);
    int n0 = got_n;
    dbl = d;
    send_frame(9'h0C9, 0, 1, -1, 0, 1'b1);
    send_frame(9'h036, 0, 1, -1, 0, 1'b0);
    send_run(1'b1, 4);
    check(got_n == n0 + 2, "R10 two chars", got_n - n0, 2);
    check(got_prev == 9'h0C9, "R10 first data", got_prev, 9'h0C9);
    check(got_data == 9'h036, "R10 second data", got_data, 9'h036);
    check(got_fe == 0, "R10 no frame error", got_fe, 0);
    dbl = 0;
  endtask

  task automatic t_hold();
    logic [8:0] snap = data_o;
    logic       fe = frame_err_o;
    int n0 = got_n;
    send_run(1'b1, 40);
    check(data_o == snap && frame_err_o == fe && got_n == n0,
          "R8 outputs hold", data_o, snap);
    check(pulse_bad == 0, "R8 pulse width", pulse_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_normal();
    t_double();
    t_majority();
    t_sizes();
    t_parity();
    t_frame_err();
    t_glitch();
    t_back_to_back(1'b0);
    t_back_to_back(1'b1);
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule